// File: doc/BRIEF.md
# Coalescing Write Buffer

This block sits between a core's store path and memory. It takes single-word stores and gathers them into line-sized entries, each covering four consecutive words, with one valid bit per word. A store whose line already has a buffered entry is folded into that entry. A store to a line that is not yet buffered opens a fresh entry. Entries leave as masked line writes, oldest-opened first, one per memory handshake.

Folding stores together saves memory bandwidth but changes the order in which lines reach memory. Take a store to line P, then a store to line Q, then another store to line P. Memory sees the combined P write before the Q write. The block is for systems that accept this write-to-write reordering across lines, with ordering enforced elsewhere.

Top module: `cwb_top`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `mem_valid` is 0 and `st_ready` is 1.
- R2: A store whose line tag (`st_addr` without its two low bits) equals the tag of a buffered entry that is not draining in that cycle joins that entry and opens no new one.
- R3: A later store to a word that is already valid in an entry replaces that word's data. The word's mask bit stays set.
- R4: A line write presents the entry's tag on `mem_line`, word k on `mem_data[k*DATA_W +: DATA_W]` and a mask bit k that is set exactly when word offset k (`st_addr[1:0]`) was stored. Words that were never stored read as zero.
- R5: Entries drain in the order in which they were opened. A handshake (`mem_valid` and `mem_ready` both high) retires exactly one entry.
- R6: Stores to X, then Y, then Z, with X and Z in one line and Y in another, give exactly two line writes. The first write carries both X and Z.
- R7: A store to the line of the entry that is draining in the same cycle opens a new entry and does not join the departing one.
- R8: When every entry is in use, `st_ready` is low for a store that matches no remaining entry and high for one that does.
- R9: While `mem_valid` is high and `mem_ready` is low, `mem_valid` stays high and `mem_line` stays unchanged. Mask bits can only be added.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| st_valid | input | 1 | Store request present |
| st_ready | output | 1 | Store can be taken this cycle |
| st_addr | input | ADDR_W | Word address of the store |
| st_data | input | DATA_W | Store data |
| mem_valid | output | 1 | A line write is offered |
| mem_ready | input | 1 | Memory takes the offered line write |
| mem_line | output | ADDR_W-2 | Line tag of the write |
| mem_mask | output | 4 | Per-word write enable |
| mem_data | output | 4*DATA_W | Line data, word 0 in the low bits |

## Verification
The bench builds the block with four entries, a 16-bit word address and 32-bit data. Random stores are drawn from only six line tags, so joins, full-buffer stalls and stores racing the draining entry all occur often. Random back-pressure on `mem_ready` holds entries long enough for later stores to join the oldest one. With four entries the full condition is reached within a few cycles, and the directed cases pin down the three-store reordering example and the race with a draining entry.

// File: rtl/cwb_pkg.sv
package cwb_pkg;
    localparam int LINE_WORDS = 4;
    localparam int OFF_W      = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_JOIN  = 2'd1,
        ST_OPEN  = 2'd2
    } st_action_e;

    function automatic logic [LINE_WORDS-1:0] word_bit(input logic [OFF_W-1:0] off);
        logic [LINE_WORDS-1:0] b;
        b = '0;
        b[off] = 1'b1;
        return b;
    endfunction
endpackage

// File: rtl/cwb_ring.sv
module cwb_ring #(
    parameter int ENTRIES = 4,
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W = $clog2(ENTRIES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    output logic [PTR_W-1:0] head,
    output logic [PTR_W-1:0] tail,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(ENTRIES - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) tail <= step(tail);
            if (pop)  head <= step(head);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign full  = (count == CNT_W'(ENTRIES));
    assign empty = (count == '0);
endmodule

// File: rtl/cwb_match.sv
module cwb_match #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 14,
    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            ent_vld,
    input  logic [ENTRIES-1:0][TAG_W-1:0] ent_tag,
    input  logic [ENTRIES-1:0]            excl,
    input  logic [TAG_W-1:0]              probe,
    output logic [ENTRIES-1:0]            match,
    output logic                          hit,
    output logic [PTR_W-1:0]              hit_idx
);
    for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
        assign match[e] = ent_vld[e] && !excl[e] && (ent_tag[e] == probe);
    end

    always_comb begin
        hit_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (match[e]) hit_idx = hit_idx | PTR_W'(e);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/cwb_line_store.sv
module cwb_line_store
    import cwb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 14,
    parameter int DATA_W  = 32,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int LINE_W = LINE_WORDS * DATA_W
) (
    input  logic                               clk,
    input  logic                               rst,
    input  logic                               open_en,
    input  logic [PTR_W-1:0]                   open_idx,
    input  logic                               join_en,
    input  logic [PTR_W-1:0]                   join_idx,
    input  logic                               retire_en,
    input  logic [PTR_W-1:0]                   retire_idx,
    input  logic [TAG_W-1:0]                   wr_tag,
    input  logic [OFF_W-1:0]                   wr_off,
    input  logic [DATA_W-1:0]                  wr_word,
    output logic [ENTRIES-1:0]                 ent_vld,
    output logic [ENTRIES-1:0][TAG_W-1:0]      ent_tag,
    output logic [ENTRIES-1:0][LINE_WORDS-1:0] ent_mask,
    output logic [ENTRIES-1:0][LINE_W-1:0]     ent_data
);
    logic [LINE_WORDS-1:0] sel;
    assign sel = word_bit(wr_off);

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic do_open, do_join, do_retire;
        assign do_open   = open_en   && (open_idx   == PTR_W'(e));
        assign do_join   = join_en   && (join_idx   == PTR_W'(e));
        assign do_retire = retire_en && (retire_idx == PTR_W'(e));

        always_ff @(posedge clk) begin
            if (rst) begin
                ent_vld[e]  <= 1'b0;
                ent_tag[e]  <= '0;
                ent_mask[e] <= '0;
                ent_data[e] <= '0;
            end else if (do_open) begin
                ent_vld[e]  <= 1'b1;
                ent_tag[e]  <= wr_tag;
                ent_mask[e] <= sel;
                for (int w = 0; w < LINE_WORDS; w++)
                    ent_data[e][w*DATA_W +: DATA_W] <= sel[w] ? wr_word : '0;
            end else if (do_join) begin
                ent_mask[e] <= ent_mask[e] | sel;
                for (int w = 0; w < LINE_WORDS; w++)
                    if (sel[w]) ent_data[e][w*DATA_W +: DATA_W] <= wr_word;
            end else if (do_retire) begin
                ent_vld[e]  <= 1'b0;
                ent_mask[e] <= '0;
            end
        end
    end
endmodule

// File: rtl/cwb_top.sv
module cwb_top
    import cwb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 32,
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int LINE_W = LINE_WORDS * DATA_W,
    localparam int PTR_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
    localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  st_valid,
    output logic                  st_ready,
    input  logic [ADDR_W-1:0]     st_addr,
    input  logic [DATA_W-1:0]     st_data,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [TAG_W-1:0]      mem_line,
    output logic [LINE_WORDS-1:0] mem_mask,
    output logic [LINE_W-1:0]     mem_data
);
    logic [PTR_W-1:0] head, tail, hit_idx;
    logic [CNT_W-1:0] count;
    logic             full, empty, hit, draining;
    logic [ENTRIES-1:0] excl, match, ent_vld;
    logic [ENTRIES-1:0][TAG_W-1:0]      ent_tag;
    logic [ENTRIES-1:0][LINE_WORDS-1:0] ent_mask;
    logic [ENTRIES-1:0][LINE_W-1:0]     ent_data;
    logic [TAG_W-1:0] st_tag;
    logic [OFF_W-1:0] st_off;
    st_action_e       act;

    assign st_tag    = st_addr[ADDR_W-1:OFF_W];
    assign st_off    = st_addr[OFF_W-1:0];
    assign mem_valid = !empty;
    assign draining  = mem_valid && mem_ready;

    always_comb begin
        excl = '0;
        if (draining) excl[head] = 1'b1;
    end

    cwb_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
        .ent_vld(ent_vld), .ent_tag(ent_tag), .excl(excl), .probe(st_tag),
        .match(match), .hit(hit), .hit_idx(hit_idx)
    );

    assign st_ready = hit || !full;

    always_comb begin
        act = ST_IDLE;
        if (st_valid && st_ready) act = hit ? ST_JOIN : ST_OPEN;
    end

    cwb_ring #(.ENTRIES(ENTRIES)) u_ring (
        .clk(clk), .rst(rst), .push(act == ST_OPEN), .pop(draining),
        .head(head), .tail(tail), .count(count), .full(full), .empty(empty)
    );

    cwb_line_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst(rst),
        .open_en(act == ST_OPEN), .open_idx(tail),
        .join_en(act == ST_JOIN), .join_idx(hit_idx),
        .retire_en(draining), .retire_idx(head),
        .wr_tag(st_tag), .wr_off(st_off), .wr_word(st_data),
        .ent_vld(ent_vld), .ent_tag(ent_tag), .ent_mask(ent_mask), .ent_data(ent_data)
    );

    assign mem_line = ent_tag[head];
    assign mem_mask = ent_mask[head];
    assign mem_data = ent_data[head];
endmodule

// File: rtl/cwb_checker.sv
module cwb_checker #(
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 14,
    parameter int CNT_W   = 3
) (
    input logic               clk,
    input logic               rst,
    input logic               st_ready,
    input logic               mem_valid,
    input logic               mem_ready,
    input logic [TAG_W-1:0]   mem_line,
    input logic [3:0]         mem_mask,
    input logic               full,
    input logic               hit,
    input logic [ENTRIES-1:0] match,
    input logic [CNT_W-1:0]   count
);
    p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!mem_valid && st_ready));

    p_single_owner_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(match));

    p_mask_present_r4: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (mem_mask != 4'b0000));

    p_bounded_fill_r5: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(ENTRIES));

    p_full_stall_r8: assert property (@(posedge clk) disable iff (rst)
        (full && !hit) |-> !st_ready);

    p_join_when_full_r8: assert property (@(posedge clk) disable iff (rst)
        hit |-> st_ready);

    p_hold_offer_r9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_line) && (($past(mem_mask) & ~mem_mask) == 4'b0000)));
endmodule

bind cwb_top cwb_checker #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .st_ready(st_ready), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_line(mem_line), .mem_mask(mem_mask),
    .full(full), .hit(hit), .match(match), .count(count)
);

// File: tb/tb_cwb_top.sv
module tb_cwb_top;
    localparam int E = 4, AW = 16, DW = 32, TW = AW - 2;

    logic clk = 0, rst = 1;
    logic st_valid = 0, mem_ready = 0, st_ready, mem_valid;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [TW-1:0] mem_line;
    logic [3:0] mem_mask;
    logic [4*DW-1:0] mem_data;

    always #5 clk = ~clk;

    cwb_top #(.ENTRIES(E), .ADDR_W(AW), .DATA_W(DW)) dut (
        .clk(clk), .rst(rst), .st_valid(st_valid), .st_ready(st_ready),
        .st_addr(st_addr), .st_data(st_data), .mem_valid(mem_valid),
        .mem_ready(mem_ready), .mem_line(mem_line), .mem_mask(mem_mask),
        .mem_data(mem_data)
    );

    int n_chk = 0, n_bad = 0;
    // reference queue, index 0 oldest
    int q_n = 0;
    logic [TW-1:0]   q_tag [E];
    logic [3:0]      q_mask[E];
    logic [4*DW-1:0] q_data[E];
    // log of observed line writes
    int wr_n = 0;
    logic [TW-1:0]   lg_tag [16];
    logic [3:0]      lg_mask[16];
    logic [4*DW-1:0] lg_data[16];

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [AW-1:0] a, input logic [DW-1:0] d, input bit mr);
        int hidx;
        bit drain, exp_rdy;
        @(negedge clk);
        st_valid = v; st_addr = a; st_data = d; mem_ready = mr;
        #1;
        chk(mem_valid == (q_n > 0), "R5 mem_valid", 128'(mem_valid), 128'(q_n > 0));
        if (q_n > 0) begin
            chk(mem_line == q_tag[0], "R5 line order", 128'(mem_line), 128'(q_tag[0]));
            chk(mem_mask == q_mask[0], "R4 mask", 128'(mem_mask), 128'(q_mask[0]));
            chk(mem_data == q_data[0], "R4 data", mem_data, q_data[0]);
        end
        drain = (q_n > 0) && mr;
        hidx = -1;
        for (int i = drain ? 1 : 0; i < q_n; i++)
            if (q_tag[i] == a[AW-1:2]) hidx = i;
        exp_rdy = (hidx >= 0) || (q_n < E);
        chk(st_ready == exp_rdy, "R8 st_ready", 128'(st_ready), 128'(exp_rdy));
        if (drain) begin
            if (wr_n < 16) begin
                lg_tag[wr_n] = mem_line; lg_mask[wr_n] = mem_mask; lg_data[wr_n] = mem_data;
            end
            wr_n++;
            for (int i = 0; i < E - 1; i++) begin
                q_tag[i] = q_tag[i+1]; q_mask[i] = q_mask[i+1]; q_data[i] = q_data[i+1];
            end
            q_n--;
            if (hidx > 0) hidx--;
        end
        if (v && exp_rdy) begin
            if (hidx < 0) begin
                hidx = q_n; q_n++;
                q_tag[hidx] = a[AW-1:2]; q_mask[hidx] = '0; q_data[hidx] = '0;
            end
            q_mask[hidx][a[1:0]] = 1'b1;
            q_data[hidx][a[1:0]*DW +: DW] = d;
        end
    endtask

    task automatic flush();
        for (int i = 0; i < 2 * E + 2; i++) step(0, '0, '0, 1);
    endtask

    function automatic logic [AW-1:0] wa(input int line, input int off);
        return AW'(line * 4 + off);
    endfunction

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int base;
        void'($urandom(32'h5eed));
        repeat (3) @(posedge clk);
        #1;
        chk(mem_valid == 0 && st_ready == 1, "R1 in reset", {mem_valid, st_ready}, 2'b01);
        @(negedge clk); rst = 0;
        #1;
        chk(mem_valid == 0 && st_ready == 1, "R1 after reset", {mem_valid, st_ready}, 2'b01);

        // R6 and R2: X(line1 w0), Y(line2 w0), Z(line1 w2)
        base = wr_n;
        step(1, wa(1, 0), 32'hA1, 0);
        step(1, wa(2, 0), 32'hB2, 0);
        step(1, wa(1, 2), 32'hC3, 0);
        flush();
        chk(wr_n - base == 2, "R6 write count", 128'(wr_n - base), 2);
        chk(lg_tag[base] == 1 && lg_mask[base] == 4'b0101, "R6 first write joins X and Z",
            {lg_tag[base], lg_mask[base]}, {14'd1, 4'b0101});
        chk(lg_data[base][2*DW +: DW] == 32'hC3, "R2 joined word", lg_data[base][2*DW +: DW], 32'hC3);

        // R3: same word twice
        base = wr_n;
        step(1, wa(5, 1), 32'h11, 0);
        step(1, wa(5, 1), 32'h22, 0);
        flush();
        chk(wr_n - base == 1 && lg_mask[base] == 4'b0010, "R3 mask", 128'(lg_mask[base]), 4'b0010);
        chk(lg_data[base][DW +: DW] == 32'h22, "R3 latest data", lg_data[base][DW +: DW], 32'h22);

        // R7: store to draining line opens a new entry
        base = wr_n;
        step(1, wa(7, 0), 32'h70, 0);
        step(1, wa(7, 3), 32'h73, 1);
        flush();
        chk(wr_n - base == 2, "R7 two writes", 128'(wr_n - base), 2);
        chk(lg_mask[base] == 4'b0001 && lg_mask[base+1] == 4'b1000, "R7 split masks",
            {lg_mask[base], lg_mask[base+1]}, {4'b0001, 4'b1000});

        // R8 and R5: fill, stall, join while full, ordered drain
        base = wr_n;
        for (int i = 0; i < E; i++) step(1, wa(10 + i, 0), 32'(i), 0);
        step(1, wa(20, 0), 32'hDEAD, 0);
        chk(st_ready == 0, "R8 stall when full", 128'(st_ready), 0);
        step(1, wa(11, 1), 32'hBEEF, 0);
        chk(st_ready == 1, "R8 join when full", 128'(st_ready), 1);
        flush();
        for (int i = 0; i < E; i++)
            chk(lg_tag[base+i] == TW'(10 + i), "R5 drain order", 128'(lg_tag[base+i]), 128'(10 + i));

        // random mix over six lines
        for (int c = 0; c < 4000; c++)
            step(($urandom % 4) != 0, wa($urandom % 6, $urandom % 4), $urandom,
                 ($urandom % 3) == 0);
        flush();
        chk(mem_valid == 0, "R5 drained", 128'(mem_valid), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule